// File: doc/BRIEF.md
# NAND Command and Address Cycle Sequencer

This block drives the control side of a raw NAND flash bus on behalf of a host controller. The host hands over one request at a time: an opcode, a block number, a page within that block and a byte column. The sequencer waits until the flash reports ready and then emits the latch bytes the opcode needs. Command bytes go out with CLE high and address bytes with ALE high, each strobed by nWE. After that it runs whichever completion the opcode calls for: a guard interval plus a wait for ready, or an immediate finish. A one-cycle `done` pulse closes every request.

Each opcode takes its own path. Spare-area reads become ordinary page reads at an offset one page further on. Random data output sends only the column and needs no busy wait. Program, erase, data-input and status opcodes return as soon as their address bytes are out. A 16-bit bus takes word columns. Moving data, ECC and timing finer than one clock are handled elsewhere.

Top module: `nand_cmd_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle, a request is taken on a clock edge with `req_valid` and `req_ready` both high, and every request ends with `done` high for exactly one cycle.
- R2: No latch byte of a request starts while `nand_rb_n` is low (0 = busy, 1 = ready) before its first byte.
- R3: Every latch byte holds `nand_we_n` low for WE_LOW_CYC cycles and then high for one cycle, with data and CLE/ALE unchanged. CLE and ALE are never high together, and `nand_ce_n` is low exactly while CLE or ALE is high.
- R4: The row is block × PAGES_PER_BLOCK + page. Address bytes go out in this order: column[7:0], column[15:8], row[7:0], row[15:8], and, when ROW3_EN is set, a fifth byte holding row[19:16] in bits 3:0 with bits 7:4 zero.
- R5: Opcode 0x00 (page read) sends the command, the full address, then confirm byte 0x30 with CLE, followed by the guard interval and the ready wait.
- R6: Opcode 0x50 (spare-area read) goes out as opcode 0x00 with column = requested column + PAGE_BYTES.
- R7: When `bus_x16` is 1, the column sent is shifted right by one bit, except for the byte-wide opcodes 0x90, 0xEC, 0xEE and 0xEF.
- R8: Opcode 0x05 (random data out) sends the command, the two column bytes and confirm byte 0xE0 with CLE, and raises `done` within two cycles of the last nWE rise, whatever the state of `nand_rb_n`.
- R9: Opcode 0xFF (reset) sends only its command byte and then runs the guard interval and the ready wait.
- R10: Opcodes 0x15, 0x10, 0x60, 0xD0, 0x80, 0x85 and 0x70 send the command and full address and raise `done` within two cycles of the last nWE rise, whatever the state of `nand_rb_n`.
- R11: Any other opcode sends the command and full address, then the guard interval and the ready wait.
- R12: On a guarded path, `done` comes no sooner than GUARD_CYC cycles after the last nWE rise and only after `nand_rb_n` has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_opcode | input | 8 | Flash opcode of the request |
| req_block | input | BLOCK_W | Erase-block number |
| req_page | input | PAGE_W | Page within the block |
| req_column | input | 16 | Byte column within the page |
| bus_x16 | input | 1 | 1 when the flash bus is 16 bits wide |
| nand_dq_out | output | 8 | Command or address byte on the bus |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_rb_n | input | 1 | Ready/busy from the flash, 1 = ready |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
A page read with the largest block and page number fills every row byte, including the top nibble, so byte order and the row product are exposed. A second page read with a small address confirms the guard interval alone. Spare-area reads run on both bus widths, and a byte-wide opcode runs on the 16-bit bus; together they separate the page-size offset from the halving and its exception. The program, erase, status and random-output opcodes run with R/B# held busy after their bytes, which tells an immediate finish from a guarded one. A read that drops R/B# after its address bytes, and a request offered while R/B# is busy, show the ready wait after the command and the ready wait before it.

// File: rtl/nand_seq_pkg.sv
// Package: opcode encodings, sequencer states and the latch-byte record
// shared by the decoder, the byte timer and the top-level control.
package nand_seq_pkg;

    localparam logic [7:0] OPC_PAGE_RD     = 8'h00;
    localparam logic [7:0] OPC_RD_CONFIRM  = 8'h30;
    localparam logic [7:0] OPC_COL_OUT     = 8'h05;
    localparam logic [7:0] OPC_COL_CONFIRM = 8'hE0;
    localparam logic [7:0] OPC_RESET       = 8'hFF;
    localparam logic [7:0] OPC_STATUS      = 8'h70;
    localparam logic [7:0] OPC_SPARE_RD    = 8'h50;
    localparam logic [7:0] OPC_DATA_IN     = 8'h80;
    localparam logic [7:0] OPC_PROG        = 8'h10;
    localparam logic [7:0] OPC_PROG_CACHE  = 8'h15;
    localparam logic [7:0] OPC_ERASE_SETUP = 8'h60;
    localparam logic [7:0] OPC_ERASE_GO    = 8'hD0;
    localparam logic [7:0] OPC_COL_IN      = 8'h85;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREWAIT,
        ST_SEND,
        ST_GUARD,
        ST_WAITRDY,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic       is_cmd;
        logic [7:0] value;
    } latch_byte_t;

    // True for opcodes that finish straight after their address bytes.
    function automatic logic op_skips_wait(input logic [7:0] op);
        case (op)
            OPC_PROG_CACHE, OPC_PROG, OPC_ERASE_SETUP, OPC_ERASE_GO,
            OPC_DATA_IN, OPC_COL_IN, OPC_STATUS: return 1'b1;
            default:                             return 1'b0;
        endcase
    endfunction

    // True for opcodes whose column is never converted to word units.
    function automatic logic op_is_byte_wide(input logic [7:0] op);
        case (op)
            8'h90, 8'hEC, 8'hEE, 8'hEF: return 1'b1;
            default:                    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/nand_req_decode.sv
// Module: nand_req_decode
// Turns a captured request into the list of latch bytes to send and says
// whether a guard interval and ready wait follow.
// Assumes: 16-bit column, row no wider than 20 bits, purely combinational.
module nand_req_decode
    import nand_seq_pkg::*;
#(
    parameter int PAGES_PER_BLOCK = 64,
    parameter int BLOCK_W         = 11,
    parameter int PAGE_BYTES      = 2048,
    parameter bit ROW3_EN         = 1'b1,
    localparam int PAGE_W         = $clog2(PAGES_PER_BLOCK),
    localparam int ROW_BYTES      = ROW3_EN ? 3 : 2,
    localparam int MAX_BYTES      = 4 + ROW_BYTES,
    localparam int LEN_W          = $clog2(MAX_BYTES + 1)
) (
    input  logic [7:0]                      opcode,
    input  logic [BLOCK_W-1:0]              block,
    input  logic [PAGE_W-1:0]               page,
    input  logic [15:0]                     column,
    input  logic                            wide_bus,
    output latch_byte_t [MAX_BYTES-1:0]     byte_list,
    output logic [LEN_W-1:0]                byte_count,
    output logic                            need_guard
);

    localparam int ROW_W    = ROW3_EN ? 20 : 16;
    localparam int CONF_POS = 3 + ROW_BYTES;

    logic [7:0]       eff_op;
    logic [15:0]      col_bytes;
    logic [15:0]      col_sent;
    logic [ROW_W-1:0] row_addr;
    logic [7:0]       row_top;

    // Opcode rewrite and column arithmetic for spare reads and word buses.
    always_comb begin
        eff_op    = (opcode == OPC_SPARE_RD) ? OPC_PAGE_RD : opcode;
        col_bytes = (opcode == OPC_SPARE_RD) ? 16'(column + 16'(PAGE_BYTES)) : column;
        col_sent  = (wide_bus && !op_is_byte_wide(eff_op)) ? (col_bytes >> 1) : col_bytes;
        row_addr  = ROW_W'(block * PAGES_PER_BLOCK + page);
    end

    // Optional fifth address byte carries only the top row nibble.
    generate
        if (ROW3_EN) begin : g_row_top
            assign row_top = {4'b0000, row_addr[ROW_W-1:16]};
        end else begin : g_no_row_top
            assign row_top = 8'h00;
        end
    endgenerate

    // Assemble the ordered latch-byte list and the completion kind.
    always_comb begin
        byte_list    = '0;
        byte_list[0] = '{is_cmd: 1'b1, value: eff_op};
        byte_count   = LEN_W'(1);
        if (eff_op != OPC_RESET) begin
            byte_list[1] = '{is_cmd: 1'b0, value: col_sent[7:0]};
            byte_list[2] = '{is_cmd: 1'b0, value: col_sent[15:8]};
            if (eff_op == OPC_COL_OUT) begin
                byte_list[3] = '{is_cmd: 1'b1, value: OPC_COL_CONFIRM};
                byte_count   = LEN_W'(4);
            end else begin
                byte_list[3] = '{is_cmd: 1'b0, value: row_addr[7:0]};
                byte_list[4] = '{is_cmd: 1'b0, value: row_addr[15:8]};
                if (ROW3_EN) begin
                    byte_list[5] = '{is_cmd: 1'b0, value: row_top};
                end
                if (eff_op == OPC_PAGE_RD) begin
                    byte_list[CONF_POS] = '{is_cmd: 1'b1, value: OPC_RD_CONFIRM};
                    byte_count          = LEN_W'(CONF_POS + 1);
                end else begin
                    byte_count          = LEN_W'(CONF_POS);
                end
            end
        end
        need_guard = !(op_skips_wait(eff_op) || eff_op == OPC_COL_OUT);
    end

endmodule

// File: rtl/nand_latch_timer.sv
// Module: nand_latch_timer
// Strobes one latch byte at a time: nWE low for WE_LOW_CYC cycles, then
// one high cycle, with data and CLE/ALE held throughout.
// Assumes: the caller keeps `go` and the byte steady until `byte_done`.
module nand_latch_timer
    import nand_seq_pkg::*;
#(
    parameter int WE_LOW_CYC = 2,
    localparam int CNT_W     = $clog2(WE_LOW_CYC + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  latch_byte_t cur_byte,
    output logic        byte_done,
    output logic [7:0]  dq_out,
    output logic        cle,
    output logic        ale,
    output logic        we_n
);

    logic [CNT_W-1:0] phase_cnt;

    // Phase counter: runs while a byte is presented, wraps after the high cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          phase_cnt <= '0;
        else if (!go)        phase_cnt <= '0;
        else if (byte_done)  phase_cnt <= '0;
        else                 phase_cnt <= phase_cnt + 1'b1;
    end

    // Bus pin drive for the byte being presented.
    always_comb begin
        byte_done = go && (phase_cnt == CNT_W'(WE_LOW_CYC));
        we_n      = !(go && !byte_done);
        dq_out    = go ? cur_byte.value : 8'h00;
        cle       = go && cur_byte.is_cmd;
        ale       = go && !cur_byte.is_cmd;
    end

    logic [CNT_W:0] chk_low_run;

    // Checker: length of the current nWE low run.
    always_ff @(posedge clk) begin
        if (!rst_n)     chk_low_run <= '0;
        else if (!we_n) chk_low_run <= chk_low_run + 1'b1;
        else            chk_low_run <= '0;
    end

    assert_cle_ale_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    assert_we_low_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_low_run <= (CNT_W+1)'(WE_LOW_CYC));

    assert_dq_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && $past(go) && !$past(byte_done)) |-> ($stable(dq_out) && $stable(cle)));

endmodule

// File: rtl/nand_guard_timer.sv
// Module: nand_guard_timer
// Counts the write-to-busy guard interval in whole clock cycles.
// Assumes: GUARD_CYC >= 1; `en` stays high until `expired`.
module nand_guard_timer #(
    parameter int GUARD_CYC = 38,
    localparam int CNT_W    = $clog2(GUARD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic expired
);

    logic [CNT_W-1:0] guard_cnt;

    assign expired = en && (guard_cnt == CNT_W'(GUARD_CYC - 1));

    // Guard counter: counts enabled cycles, clears when idle or expired.
    always_ff @(posedge clk) begin
        if (!rst_n)             guard_cnt <= '0;
        else if (!en || expired) guard_cnt <= '0;
        else                    guard_cnt <= guard_cnt + 1'b1;
    end

    assert_expire_enabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> $past(en) || (GUARD_CYC == 1));

endmodule

// File: rtl/nand_cmd_seq.sv
// Module: nand_cmd_seq (top)
// Takes one request, waits for ready, sends its latch bytes and runs the
// opcode's completion (guard + ready wait, or immediate), then pulses done.
// Assumes: nand_rb_n is already synchronous to clk.
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int PAGES_PER_BLOCK = 64,
    parameter int BLOCK_W         = 11,
    parameter int PAGE_BYTES      = 2048,
    parameter bit ROW3_EN         = 1'b1,
    parameter int WE_LOW_CYC      = 2,
    parameter int GUARD_CYC       = 38,
    localparam int PAGE_W         = $clog2(PAGES_PER_BLOCK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [7:0]         req_opcode,
    input  logic [BLOCK_W-1:0] req_block,
    input  logic [PAGE_W-1:0]  req_page,
    input  logic [15:0]        req_column,
    input  logic               bus_x16,
    output logic [7:0]         nand_dq_out,
    output logic               nand_cle,
    output logic               nand_ale,
    output logic               nand_ce_n,
    output logic               nand_we_n,
    input  logic               nand_rb_n,
    output logic               done
);

    localparam int ROW_BYTES = ROW3_EN ? 3 : 2;
    localparam int MAX_BYTES = 4 + ROW_BYTES;
    localparam int LEN_W     = $clog2(MAX_BYTES + 1);

    seq_state_t         state;
    logic [7:0]         op_q;
    logic [BLOCK_W-1:0] blk_q;
    logic [PAGE_W-1:0]  pg_q;
    logic [15:0]        col_q;
    logic               x16_q;
    logic [LEN_W-1:0]   idx_q;

    latch_byte_t [MAX_BYTES-1:0] byte_list;
    logic [LEN_W-1:0]            byte_count;
    logic                        need_guard;
    logic                        byte_done;
    logic                        guard_expired;
    logic                        last_byte;

    nand_req_decode #(
        .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
        .BLOCK_W        (BLOCK_W),
        .PAGE_BYTES     (PAGE_BYTES),
        .ROW3_EN        (ROW3_EN)
    ) u_decode (
        .opcode    (op_q),
        .block     (blk_q),
        .page      (pg_q),
        .column    (col_q),
        .wide_bus  (x16_q),
        .byte_list (byte_list),
        .byte_count(byte_count),
        .need_guard(need_guard)
    );

    nand_latch_timer #(.WE_LOW_CYC(WE_LOW_CYC)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (state == ST_SEND),
        .cur_byte (byte_list[idx_q]),
        .byte_done(byte_done),
        .dq_out   (nand_dq_out),
        .cle      (nand_cle),
        .ale      (nand_ale),
        .we_n     (nand_we_n)
    );

    nand_guard_timer #(.GUARD_CYC(GUARD_CYC)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (state == ST_GUARD),
        .expired(guard_expired)
    );

    // Handshake and end-of-request outputs.
    always_comb begin
        req_ready = (state == ST_IDLE);
        done      = (state == ST_DONE);
        nand_ce_n = (state != ST_SEND);
        last_byte = (idx_q == byte_count - 1'b1);
    end

    // Request capture, latch-byte index and state sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            op_q  <= '0;
            blk_q <= '0;
            pg_q  <= '0;
            col_q <= '0;
            x16_q <= 1'b0;
            idx_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    op_q  <= req_opcode;
                    blk_q <= req_block;
                    pg_q  <= req_page;
                    col_q <= req_column;
                    x16_q <= bus_x16;
                    idx_q <= '0;
                    state <= ST_PREWAIT;
                end
                ST_PREWAIT: if (nand_rb_n) state <= ST_SEND;
                ST_SEND: if (byte_done) begin
                    if (last_byte) state <= need_guard ? ST_GUARD : ST_DONE;
                    else           idx_q <= idx_q + 1'b1;
                end
                ST_GUARD:   if (guard_expired) state <= ST_WAITRDY;
                ST_WAITRDY: if (nand_rb_n)     state <= ST_DONE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    assert_prewait_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PREWAIT && !nand_rb_n) |=> nand_ce_n);

    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    assert_ready_wait_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAITRDY && !nand_rb_n) |=> !done);

    assert_ce_tracks_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        nand_ce_n == !(nand_cle || nand_ale));

endmodule

// File: tb/tb_nand_cmd_seq.sv
// Directed bench for nand_cmd_seq: one task per scenario.
module tb_nand_cmd_seq;

    localparam int PAGES = 64;
    localparam int BW    = 11;
    localparam int PB    = 2048;
    localparam int WEL   = 2;
    localparam int G     = 38;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_opcode = '0;
    logic [BW-1:0] req_block = '0;
    logic [5:0]  req_page = '0;
    logic [15:0] req_column = '0;
    logic        bus_x16 = 1'b0;
    logic [7:0]  nand_dq_out;
    logic        nand_cle, nand_ale, nand_ce_n, nand_we_n;
    logic        nand_rb_n = 1'b1;
    logic        done;

    always #2 clk = ~clk;

    nand_cmd_seq #(
        .PAGES_PER_BLOCK(PAGES), .BLOCK_W(BW), .PAGE_BYTES(PB),
        .ROW3_EN(1'b1), .WE_LOW_CYC(WEL), .GUARD_CYC(G)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_opcode(req_opcode), .req_block(req_block), .req_page(req_page),
        .req_column(req_column), .bus_x16(bus_x16), .nand_dq_out(nand_dq_out),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce_n(nand_ce_n),
        .nand_we_n(nand_we_n), .nand_rb_n(nand_rb_n), .done(done)
    );

    int n_chk = 0, n_err = 0;
    int cyc = 0;
    int mon_err, low_run, cap_n, last_rise, first_fall, done_seen, done_cyc, done_len;
    logic prev_we = 1'b1;
    logic [7:0] cap_byte [16];
    logic       cap_cle  [16];
    logic [7:0] exp_byte [8];
    logic       exp_cle  [8];
    int exp_n;

    // Bus monitor: sampled mid-cycle, records each latched byte.
    always @(negedge clk) begin
        cyc++;
        if (nand_cle && nand_ale) mon_err++;
        if (nand_ce_n != !(nand_cle || nand_ale)) mon_err++;
        if (!nand_we_n) low_run++;
        if (!nand_we_n && prev_we && first_fall < 0) first_fall = cyc;
        if (nand_we_n && !prev_we) begin
            if (low_run != WEL) mon_err++;
            if (cap_n < 16) begin
                cap_byte[cap_n] = nand_dq_out;
                cap_cle[cap_n]  = nand_cle;
            end
            cap_n++;
            last_rise = cyc;
            low_run = 0;
        end
        if (done) begin
            if (!done_seen) done_cyc = cyc;
            done_seen = 1;
            done_len++;
        end
        prev_we = nand_we_n;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected latch bytes built from the requirement rules.
    task automatic build_exp(input logic [7:0] op, input int blk, input int pg,
                             input int col, input bit x16);
        logic [7:0] e_op;
        int c, row;
        e_op = (op == 8'h50) ? 8'h00 : op;
        c = (op == 8'h50) ? col + PB : col;
        if (x16 && !(e_op == 8'h90 || e_op == 8'hEC || e_op == 8'hEE || e_op == 8'hEF)) c = c >> 1;
        row = blk * PAGES + pg;
        exp_byte[0] = e_op; exp_cle[0] = 1'b1; exp_n = 1;
        if (e_op != 8'hFF) begin
            exp_byte[1] = c[7:0];  exp_cle[1] = 1'b0;
            exp_byte[2] = c[15:8]; exp_cle[2] = 1'b0;
            exp_n = 3;
            if (e_op == 8'h05) begin
                exp_byte[3] = 8'hE0; exp_cle[3] = 1'b1; exp_n = 4;
            end else begin
                exp_byte[3] = row[7:0];   exp_cle[3] = 1'b0;
                exp_byte[4] = row[15:8];  exp_cle[4] = 1'b0;
                exp_byte[5] = {4'h0, row[19:16]}; exp_cle[5] = 1'b0;
                exp_n = 6;
                if (e_op == 8'h00) begin
                    exp_byte[6] = 8'h30; exp_cle[6] = 1'b1; exp_n = 7;
                end
            end
        end
    endtask

    // Run one request. mode 0: ready throughout; 1: busy until rel cycles
    // after acceptance; 2: busy for 60 cycles after the last byte;
    // 3: busy from the last byte until done.
    task automatic run_req(input string tag, input logic [7:0] op, input int blk,
                           input int pg, input int col, input bit x16,
                           input int mode, input int rel, output int rel_cyc);
        int busy_t;
        busy_t = -1; rel_cyc = -1;
        build_exp(op, blk, pg, col, x16);
        @(negedge clk); #1;
        mon_err = 0; low_run = 0; cap_n = 0; last_rise = -1; first_fall = -1;
        done_seen = 0; done_cyc = -1; done_len = 0;
        req_opcode = op; req_block = BW'(blk); req_page = 6'(pg);
        req_column = 16'(col); bus_x16 = x16; req_valid = 1'b1;
        nand_rb_n = (mode == 1) ? 1'b0 : 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
        chk({tag, " R1 ready low while busy"}, int'(req_ready), 0);
        for (int i = 0; i < 4000; i++) begin
            if (done_seen) break;
            if (mode == 1 && i == rel) begin nand_rb_n = 1'b1; rel_cyc = cyc; end
            if (mode >= 2 && cap_n == exp_n && busy_t < 0) begin nand_rb_n = 1'b0; busy_t = cyc; end
            if (mode == 2 && busy_t >= 0 && rel_cyc < 0 && cyc >= busy_t + 60) begin
                nand_rb_n = 1'b1; rel_cyc = cyc;
            end
            @(negedge clk); #1;
        end
        nand_rb_n = 1'b1;
        chk({tag, " R1 done seen"}, done_seen, 1);
        @(negedge clk); #1;
        @(negedge clk); #1;
        chk({tag, " R1 done one cycle"}, done_len, 1);
        chk({tag, " R1 ready after done"}, int'(req_ready), 1);
        chk({tag, " R3 bus timing"}, mon_err, 0);
        chk({tag, " R4 byte count"}, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++)
            chk($sformatf("%s R4 byte %0d", tag, i),
                int'({cap_cle[i], cap_byte[i]}), int'({exp_cle[i], exp_byte[i]}));
    endtask

    task automatic t_reset_state;
        chk("R1 ready after reset", int'(req_ready), 1);
        chk("R1 done low after reset", int'(done), 0);
        chk("R3 idle pins", int'({nand_ce_n, nand_we_n, nand_cle, nand_ale}), 4'b1100);
    endtask

    task automatic t_page_read_far;
        int r;
        run_req("read far R5", 8'h00, 2047, 63, 16'h0123, 1'b0, 2, 0, r);
        chk("R12 done after ready", int'(done_cyc > r), 1);
        chk("R12 guard length", int'(done_cyc - last_rise >= G), 1);
    endtask

    task automatic t_page_read_near;
        int r;
        run_req("read near R5", 8'h00, 5, 3, 16'h0040, 1'b0, 0, 0, r);
        chk("R12 guard length", int'(done_cyc - last_rise >= G), 1);
    endtask

    task automatic t_spare_read;
        int r;
        run_req("spare x8 R6", 8'h50, 9, 1, 16'h0010, 1'b0, 0, 0, r);
        run_req("spare x16 R6 R7", 8'h50, 9, 1, 16'h0010, 1'b1, 0, 0, r);
    endtask

    task automatic t_byte_wide_x16;
        int r;
        run_req("byte-wide x16 R7 R11", 8'h90, 0, 0, 16'h0020, 1'b1, 0, 0, r);
        chk("R11 guard length", int'(done_cyc - last_rise >= G), 1);
    endtask

    task automatic t_col_out;
        int r;
        run_req("col out R8", 8'h05, 3, 2, 16'h0456, 1'b0, 3, 0, r);
        chk("R8 no wait", int'(done_cyc - last_rise <= 2), 1);
    endtask

    task automatic t_flash_reset;
        int r;
        run_req("reset R9", 8'hFF, 7, 7, 16'h0777, 1'b0, 0, 0, r);
        chk("R9 guard length", int'(done_cyc - last_rise >= G), 1);
    endtask

    task automatic t_no_wait_ops;
        logic [7:0] ops [7] = '{8'h15, 8'h10, 8'h60, 8'hD0, 8'h80, 8'h85, 8'h70};
        int r;
        for (int k = 0; k < 7; k++) begin
            run_req($sformatf("no-wait op %02h R10", ops[k]), ops[k], 100 + k, k, 16'h0200 + k,
                    1'b0, 3, 0, r);
            chk($sformatf("R10 op %02h immediate", ops[k]), int'(done_cyc - last_rise <= 2), 1);
        end
    endtask

    task automatic t_prewait;
        int r;
        run_req("prewait R2", 8'h70, 1, 1, 0, 1'b0, 1, 20, r);
        chk("R2 first byte after ready", int'(first_fall > r), 1);
    endtask

    // Watchdog: a hung run still reaches the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset_state();
        t_page_read_far();
        t_page_read_near();
        t_spare_read();
        t_byte_wide_x16();
        t_col_out();
        t_flash_reset();
        t_no_wait_ops();
        t_prewait();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule